// File: doc/BRIEF.md
# Paired-Page Translation Lookup

This block translates a virtual address through a small, fully associative set of translation entries. Each entry covers two neighbouring virtual pages, an even one and an odd one, under a single tag. Each half carries its own frame number, a valid flag and a dirty flag. A per-entry size mask widens the page beyond the minimum size. The lookup compares all entries at once. The lowest-numbered matching entry is used. One clock edge later the block returns a registered result code together with the translated address and the access permissions.

A failed lookup does not return a translation. Instead it returns the values that the fault-context register and the entry-high register should take, so that a fault handler can load them directly. Entries are loaded through a synchronous write port that takes an index. Clearing the valid flags of every entry at reset makes the whole structure empty.

Top module: `tlbPairLookup`

## Requirements
- R1: After reset no entry is in use, `rspValid` is 0 and `rspRead`/`rspWrite` are 0; any lookup issued before an entry is written returns code 3 (no-match).
- R2: An entry in use takes part in a lookup only when its global flag is set or its stored 8-bit ID equals `curEntryHi[7:0]`, and its stored page number equals the address on every bit outside its combined mask.
- R3: The combined mask of an entry is `wrMask` OR-ed with `0x1FFF` (two 4 KiB pages), so address bits 12:0 and the `wrMask` bits never take part in the tag comparison.
- R4: The half is picked by the highest set bit of the combined mask (bit 12 when `wrMask` is 0). That bit is 0 for the even half and 1 for the odd half. On a match, `rspPhys` is that half's frame number OR-ed with the address bits under the combined mask shifted right by one.
- R5: When the selected half's valid flag is clear, the result code is 1 (invalid).
- R6: A write lookup (`lkWrite`=1) to a valid half whose dirty flag is clear returns code 2 (modified). A read lookup to a valid half returns code 0 (match) whatever the dirty flag is.
- R7: On code 0, `rspRead` is 1 and `rspWrite` equals the selected half's dirty flag. On any other code, `rspRead`, `rspWrite` and `rspPhys` are 0.
- R8: When no entry in use satisfies R2, the code is 3 (no-match), and this is the flag that a refill handler uses.
- R9: On codes 1 to 3, `rspContext` is `curContext[31:23]` kept, bits 22:4 equal to `lkAddr[31:13]`, and bits 3:0 zero. `rspEntryHi` is `lkAddr[31:13]` in bits 31:13, zeros in bits 12:8, and `curEntryHi[7:0]` in bits 7:0. On code 0 both return `curContext` and `curEntryHi` unchanged.
- R10: When several entries match, the entry with the lowest index decides the result.
- R11: A lookup presented at a clock edge is answered, with `rspValid`=1, at the outputs after that edge, and `rspValid` drops again after the next edge unless a new lookup is presented. The result fields hold until the next lookup. An entry write takes effect at its edge. A lookup at the same edge still sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request this cycle |
| lkAddr | input | VA_W (32) | Virtual address to translate |
| lkWrite | input | 1 | 1 = store access, 0 = load access |
| curEntryHi | input | VA_W (32) | Current entry-high value; low 8 bits are the active ID |
| curContext | input | VA_W (32) | Current fault-context value |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | log2(ENTRIES) (3) | Entry index to write |
| wrVpn | input | VA_W (32) | Page-pair tag of the entry |
| wrMask | input | VA_W (32) | Page size mask of the entry |
| wrAsid | input | ASID_W (8) | Address-space ID of the entry |
| wrGlobal | input | 1 | Entry ignores the ID comparison |
| wrPfnEven | input | VA_W (32) | Frame base of the even half |
| wrPfnOdd | input | VA_W (32) | Frame base of the odd half |
| wrValidEven | input | 1 | Even half valid |
| wrValidOdd | input | 1 | Odd half valid |
| wrDirtyEven | input | 1 | Even half writable |
| wrDirtyOdd | input | 1 | Odd half writable |
| rspValid | output | 1 | Result present this cycle |
| rspCode | output | 2 | 0 match, 1 invalid, 2 modified, 3 no-match |
| rspPhys | output | VA_W (32) | Translated address |
| rspRead | output | 1 | Read permitted |
| rspWrite | output | 1 | Write permitted |
| rspContext | output | VA_W (32) | Fault-context value to load |
| rspEntryHi | output | VA_W (32) | Entry-high value to load |

## Verification
The assertions rely on the input masks being contiguous runs of ones starting at bit 13. This keeps the half-select bit and the offset field well defined. They also rely on `wrIdx` staying below the entry count. The stimulus draws every mask from three such shapes and every index from the legal range. It makes matching addresses by filling the masked bits of a stored tag. It picks IDs from a small pool, so that ID mismatches, global entries and duplicate tags all occur often.

// File: rtl/tlbPairPkg.sv
package tlbPairPkg;

  typedef enum logic [1:0] {
    RES_MATCH    = 2'd0,
    RES_INVALID  = 2'd1,
    RES_MODIFIED = 2'd2,
    RES_NOMATCH  = 2'd3
  } resCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic entryWrite;  // load the addressed entry
    logic capture;     // register a lookup result
    logic grant;       // captured lookup is a successful translation
  } pathStrobe_t;

  // fault-context layout: kept high field and address-derived field
  localparam logic [31:0] CTX_KEEP  = 32'hFF80_0000;
  localparam logic [31:0] CTX_FIELD = 32'h007F_FFF0;
  localparam int          CTX_SHIFT = 9;

endpackage

// File: rtl/tlbPairPath.sv
module tlbPairPath
  import tlbPairPkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ASID_W     = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int VA_W       = 32,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  pathStrobe_t         strobe,
  input  logic [IDX_W-1:0]    winIdx,
  input  logic [VA_W-1:0]     lkAddr,
  input  logic [VA_W-1:0]     curEntryHi,
  input  logic [VA_W-1:0]     curContext,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [VA_W-1:0]     wrVpn,
  input  logic [VA_W-1:0]     wrMask,
  input  logic [ASID_W-1:0]   wrAsid,
  input  logic                wrGlobal,
  input  logic [VA_W-1:0]     wrPfnEven,
  input  logic [VA_W-1:0]     wrPfnOdd,
  input  logic                wrValidEven,
  input  logic                wrValidOdd,
  input  logic                wrDirtyEven,
  input  logic                wrDirtyOdd,
  output logic [ENTRIES-1:0]  hitVec,
  output logic [ENTRIES-1:0]  selValid,
  output logic [ENTRIES-1:0]  selDirty,
  output logic [VA_W-1:0]     physOut,
  output logic                readOk,
  output logic                writeOk,
  output logic [VA_W-1:0]     ctxOut,
  output logic [VA_W-1:0]     ehOut
);

  // two minimum pages always sit under the mask
  localparam logic [VA_W-1:0] MIN_MASK = (VA_W'(1) << (PAGE_SHIFT + 1)) - VA_W'(1);
  localparam logic [VA_W-1:0] ID_MASK  = (VA_W'(1) << ASID_W) - VA_W'(1);

  // entry storage
  logic                entUsed  [ENTRIES];
  logic [VA_W-1:0]     entVpn   [ENTRIES];
  logic [VA_W-1:0]     entMask  [ENTRIES];
  logic [ASID_W-1:0]   entAsid  [ENTRIES];
  logic                entGlob  [ENTRIES];
  logic [VA_W-1:0]     entPfnE  [ENTRIES];
  logic [VA_W-1:0]     entPfnO  [ENTRIES];
  logic                entValE  [ENTRIES];
  logic                entValO  [ENTRIES];
  logic                entDirE  [ENTRIES];
  logic                entDirO  [ENTRIES];

  logic [ASID_W-1:0]   curAsid;
  logic [VA_W-1:0]     framePick [ENTRIES];
  logic [VA_W-1:0]     offsPick  [ENTRIES];

  assign curAsid = curEntryHi[ASID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entUsed[i] <= 1'b0;
        entVpn[i]  <= '0;
        entMask[i] <= '0;
        entAsid[i] <= '0;
        entGlob[i] <= 1'b0;
        entPfnE[i] <= '0;
        entPfnO[i] <= '0;
        entValE[i] <= 1'b0;
        entValO[i] <= 1'b0;
        entDirE[i] <= 1'b0;
        entDirO[i] <= 1'b0;
      end
    end else if (strobe.entryWrite) begin
      entUsed[wrIdx] <= 1'b1;
      entVpn[wrIdx]  <= wrVpn;
      entMask[wrIdx] <= wrMask;
      entAsid[wrIdx] <= wrAsid;
      entGlob[wrIdx] <= wrGlobal;
      entPfnE[wrIdx] <= wrPfnEven;
      entPfnO[wrIdx] <= wrPfnOdd;
      entValE[wrIdx] <= wrValidEven;
      entValO[wrIdx] <= wrValidOdd;
      entDirE[wrIdx] <= wrDirtyEven;
      entDirO[wrIdx] <= wrDirtyOdd;
    end
  end

  // parallel compare, one slice per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gSlice
    logic [VA_W-1:0] fullMask;
    logic [VA_W-1:0] halfBit;
    logic            idOk;
    logic            tagOk;
    logic            oddHalf;

    assign fullMask = entMask[g] | MIN_MASK;
    assign halfBit  = fullMask & ~(fullMask >> 1);
    assign idOk     = entGlob[g] || (entAsid[g] == curAsid);
    assign tagOk    = ((lkAddr ^ entVpn[g]) & ~fullMask) == '0;
    assign oddHalf  = |(lkAddr & halfBit);

    assign hitVec[g]    = entUsed[g] && idOk && tagOk;
    assign selValid[g]  = oddHalf ? entValO[g] : entValE[g];
    assign selDirty[g]  = oddHalf ? entDirO[g] : entDirE[g];
    assign framePick[g] = oddHalf ? entPfnO[g] : entPfnE[g];
    assign offsPick[g]  = lkAddr & (fullMask >> 1);
  end

  logic [VA_W-1:0] faultCtx;
  logic [VA_W-1:0] faultEh;

  assign faultCtx = (curContext & VA_W'(CTX_KEEP)) |
                    ((lkAddr >> CTX_SHIFT) & VA_W'(CTX_FIELD));
  assign faultEh  = (curEntryHi & ID_MASK) | (lkAddr & ~MIN_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physOut <= '0;
      readOk  <= 1'b0;
      writeOk <= 1'b0;
      ctxOut  <= '0;
      ehOut   <= '0;
    end else if (strobe.capture) begin
      if (strobe.grant) begin
        physOut <= framePick[winIdx] | offsPick[winIdx];
        readOk  <= 1'b1;
        writeOk <= selDirty[winIdx];
        ctxOut  <= curContext;
        ehOut   <= curEntryHi;
      end else begin
        physOut <= '0;
        readOk  <= 1'b0;
        writeOk <= 1'b0;
        ctxOut  <= faultCtx;
        ehOut   <= faultEh;
      end
    end
  end

endmodule

// File: rtl/tlbPairCtrl.sv
module tlbPairCtrl
  import tlbPairPkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               lkWrite,
  input  logic               wrEn,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] selValid,
  input  logic [ENTRIES-1:0] selDirty,
  output pathStrobe_t        strobe,
  output logic [IDX_W-1:0]   winIdx,
  output logic               rspValid,
  output logic [1:0]         rspCode
);

  logic     anyHit;
  resCode_e nextCode;

  // lowest index wins
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i] && !anyHit) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!anyHit)
      nextCode = RES_NOMATCH;
    else if (!selValid[winIdx])
      nextCode = RES_INVALID;
    else if (lkWrite && !selDirty[winIdx])
      nextCode = RES_MODIFIED;
    else
      nextCode = RES_MATCH;
  end

  always_comb begin
    strobe.entryWrite = wrEn;
    strobe.capture    = lkValid;
    strobe.grant      = (nextCode == RES_MATCH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= 2'd0;
    end else begin
      rspValid <= lkValid;
      if (lkValid) rspCode <= nextCode;
    end
  end

endmodule

// File: rtl/tlbPairLookup.sv
module tlbPairLookup
  import tlbPairPkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int ASID_W     = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int VA_W       = 32,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkAddr,
  input  logic              lkWrite,
  input  logic [VA_W-1:0]   curEntryHi,
  input  logic [VA_W-1:0]   curContext,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VA_W-1:0]   wrVpn,
  input  logic [VA_W-1:0]   wrMask,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [VA_W-1:0]   wrPfnEven,
  input  logic [VA_W-1:0]   wrPfnOdd,
  input  logic              wrValidEven,
  input  logic              wrValidOdd,
  input  logic              wrDirtyEven,
  input  logic              wrDirtyOdd,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [VA_W-1:0]   rspPhys,
  output logic              rspRead,
  output logic              rspWrite,
  output logic [VA_W-1:0]   rspContext,
  output logic [VA_W-1:0]   rspEntryHi
);

  pathStrobe_t        strobe;
  logic [IDX_W-1:0]   winIdx;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] selValid;
  logic [ENTRIES-1:0] selDirty;

  tlbPairCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lkValid  (lkValid),
    .lkWrite  (lkWrite),
    .wrEn     (wrEn),
    .hitVec   (hitVec),
    .selValid (selValid),
    .selDirty (selDirty),
    .strobe   (strobe),
    .winIdx   (winIdx),
    .rspValid (rspValid),
    .rspCode  (rspCode)
  );

  tlbPairPath #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT), .VA_W(VA_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .winIdx      (winIdx),
    .lkAddr      (lkAddr),
    .curEntryHi  (curEntryHi),
    .curContext  (curContext),
    .wrIdx       (wrIdx),
    .wrVpn       (wrVpn),
    .wrMask      (wrMask),
    .wrAsid      (wrAsid),
    .wrGlobal    (wrGlobal),
    .wrPfnEven   (wrPfnEven),
    .wrPfnOdd    (wrPfnOdd),
    .wrValidEven (wrValidEven),
    .wrValidOdd  (wrValidOdd),
    .wrDirtyEven (wrDirtyEven),
    .wrDirtyOdd  (wrDirtyOdd),
    .hitVec      (hitVec),
    .selValid    (selValid),
    .selDirty    (selDirty),
    .physOut     (rspPhys),
    .readOk      (rspRead),
    .writeOk     (rspWrite),
    .ctxOut      (rspContext),
    .ehOut       (rspEntryHi)
  );

endmodule

// File: rtl/tlbPairLookupChk.sv
module tlbPairLookupChk #(
  parameter int ASID_W = 8,
  parameter int VA_W   = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic            lkWrite,
  input logic [VA_W-1:0] curEntryHi,
  input logic            rspValid,
  input logic [1:0]      rspCode,
  input logic            rspRead,
  input logic            rspWrite,
  input logic [VA_W-1:0] rspContext,
  input logic [VA_W-1:0] rspEntryHi
);

  // R7: a successful translation always grants read
  assert_match_reads_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == 2'd0) |-> rspRead);

  // R7: write permission only accompanies a match
  assert_write_needs_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspWrite |-> (rspCode == 2'd0 && rspRead));

  // R9: fault outputs keep the active ID and clear the context low nibble
  assert_fault_keeps_id_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode != 2'd0) |->
      (rspEntryHi[ASID_W-1:0] == $past(curEntryHi[ASID_W-1:0]) && rspContext[3:0] == 4'd0));

  // R6: the modified outcome only comes from a store access
  assert_modified_is_store_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == 2'd2) |-> $past(lkWrite));

  // R11: every response answers a request one edge earlier
  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(lkValid));

endmodule

bind tlbPairLookup tlbPairLookupChk #(.ASID_W(ASID_W), .VA_W(VA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lkValid    (lkValid),
  .lkWrite    (lkWrite),
  .curEntryHi (curEntryHi),
  .rspValid   (rspValid),
  .rspCode    (rspCode),
  .rspRead    (rspRead),
  .rspWrite   (rspWrite),
  .rspContext (rspContext),
  .rspEntryHi (rspEntryHi)
);

// File: tb/test_tlbPairLookup.sv
`timescale 1ns/1ps
module test_tlbPairLookup;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        lkWrite = 1'b0;
  logic [31:0] curEntryHi = '0;
  logic [31:0] curContext = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrVpn = '0, wrMask = '0, wrPfnEven = '0, wrPfnOdd = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0, wrValidEven = 1'b0, wrValidOdd = 1'b0;
  logic        wrDirtyEven = 1'b0, wrDirtyOdd = 1'b0;
  logic        rspValid, rspRead, rspWrite;
  logic [1:0]  rspCode;
  logic [31:0] rspPhys, rspContext, rspEntryHi;

  tlbPairLookup i_tlbPairLookup (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference entries
  logic        mUsed [N];
  logic [31:0] mVpn [N], mMask [N], mPfnE [N], mPfnO [N];
  logic [7:0]  mAsid [N];
  logic        mGlob [N], mValE [N], mValO [N], mDirE [N], mDirO [N];

  task automatic chk(input bit ok, input string tag, input logic [131:0] act, input logic [131:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input logic w, input logic [31:0] eh,
                       input logic [31:0] ctx, output logic [1:0] code,
                       output logic [31:0] ph, output logic rd, output logic wo,
                       output logic [31:0] octx, output logic [31:0] oeh);
    int   hit;
    logic odd;
    logic v, d;
    logic [31:0] fm;
    hit = -1;
    for (int i = N - 1; i >= 0; i--) begin
      fm = mMask[i] | 32'h1FFF;
      if (mUsed[i] && (mGlob[i] || mAsid[i] == eh[7:0]) && ((a & ~fm) == (mVpn[i] & ~fm)))
        hit = i;
    end
    code = 2'd3; ph = '0; rd = 0; wo = 0;
    if (hit >= 0) begin
      fm  = mMask[hit] | 32'h1FFF;
      odd = |(a & fm & ~(fm >> 1));
      v   = odd ? mValO[hit] : mValE[hit];
      d   = odd ? mDirO[hit] : mDirE[hit];
      if (!v) code = 2'd1;
      else if (w && !d) code = 2'd2;
      else begin
        code = 2'd0;
        ph = (odd ? mPfnO[hit] : mPfnE[hit]) | (a & (fm >> 1));
        rd = 1; wo = d;
      end
    end
    if (code == 2'd0) begin
      octx = ctx; oeh = eh;
    end else begin
      octx = {ctx[31:23], a[31:13], 4'h0};
      oeh  = {a[31:13], 5'h0, eh[7:0]};
    end
  endtask

  task automatic modelWrite(input int i, input logic [31:0] vpn, input logic [31:0] msk,
                            input logic [7:0] id, input logic g, input logic [31:0] pe,
                            input logic [31:0] po, input logic ve, input logic vo,
                            input logic de, input logic dd);
    mUsed[i] = 1; mVpn[i] = vpn; mMask[i] = msk; mAsid[i] = id; mGlob[i] = g;
    mPfnE[i] = pe; mPfnO[i] = po; mValE[i] = ve; mValO[i] = vo; mDirE[i] = de; mDirO[i] = dd;
  endtask

  task automatic driveWrite(input int i, input logic [31:0] vpn, input logic [31:0] msk,
                            input logic [7:0] id, input logic g, input logic [31:0] pe,
                            input logic [31:0] po, input logic ve, input logic vo,
                            input logic de, input logic dd);
    wrEn = 1; wrIdx = 3'(i); wrVpn = vpn; wrMask = msk; wrAsid = id; wrGlobal = g;
    wrPfnEven = pe; wrPfnOdd = po; wrValidEven = ve; wrValidOdd = vo;
    wrDirtyEven = de; wrDirtyOdd = dd;
  endtask

  task automatic doWrite(input int i, input logic [31:0] vpn, input logic [31:0] msk,
                         input logic [7:0] id, input logic g, input logic [31:0] pe,
                         input logic [31:0] po, input logic ve, input logic vo,
                         input logic de, input logic dd);
    @(negedge clk);
    driveWrite(i, vpn, msk, id, g, pe, po, ve, vo, de, dd);
    @(negedge clk);
    wrEn = 0;
    modelWrite(i, vpn, msk, id, g, pe, po, ve, vo, de, dd);
  endtask

  // expected values are computed before the edge; compared after it
  task automatic checkResp(input string tag, input logic [1:0] code, input logic [31:0] ph,
                           input logic rd, input logic wo, input logic [31:0] octx,
                           input logic [31:0] oeh);
    logic [131:0] act, exp;
    act = {rspValid, rspCode, rspPhys, rspRead, rspWrite, rspContext, rspEntryHi};
    exp = {1'b1, code, ph, rd, wo, octx, oeh};
    chk(act == exp, tag, act, exp);
  endtask

  task automatic doLookup(input logic [31:0] a, input logic w, input logic [31:0] eh,
                          input logic [31:0] ctx, input string tag);
    logic [1:0] code; logic [31:0] ph, octx, oeh; logic rd, wo;
    model(a, w, eh, ctx, code, ph, rd, wo, octx, oeh);
    @(negedge clk);
    lkValid = 1; lkAddr = a; lkWrite = w; curEntryHi = eh; curContext = ctx;
    @(negedge clk);
    lkValid = 0;
    checkResp(tag, code, ph, rd, wo, octx, oeh);
  endtask

  string tagByCode [4] = '{"R4 R7 R9 match", "R5 invalid", "R6 modified", "R8 R9 no-match"};

  initial begin
    logic [1:0] code; logic [31:0] ph, octx, oeh; logic rd, wo;
    for (int i = 0; i < N; i++) modelWrite(i, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < N; i++) mUsed[i] = 0;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(rspValid == 0 && rspRead == 0 && rspWrite == 0, "R1 reset outputs",
        {rspValid, rspRead, rspWrite}, 0);
    doLookup(32'h0040_0000, 0, 32'h0000_0005, 32'h1234_5678, "R1 empty table no-match");

    // entry 0: 4 KiB pair, ID 5, even clean-dirty, odd valid read-only
    doWrite(0, 32'h0040_0000, 0, 8'h05, 0, 32'h1000_0000, 32'h2000_0000, 1, 1, 1, 0);
    doLookup(32'h0040_0123, 0, 32'hAAAA_A005, 32'hFFFF_FFFF, "R2 R4 R7 even read");
    chk(rspPhys == 32'h1000_0123, "R4 even frame", rspPhys, 32'h1000_0123);
    doLookup(32'h0040_1456, 0, 32'h0000_0005, 32'h0, "R4 R6 R7 odd read clean");
    chk(rspPhys == 32'h2000_0456 && rspWrite == 0, "R7 odd no write perm",
        {rspPhys, rspWrite}, {32'h2000_0456, 1'b0});
    doLookup(32'h0040_1456, 1, 32'h0000_0005, 32'h0, "R6 store to clean half");
    chk(rspCode == 2'd2, "R6 modified code", rspCode, 2'd2);
    doLookup(32'h0040_0010, 1, 32'h0000_0005, 32'h0, "R6 store to dirty half");
    doLookup(32'h0040_0010, 0, 32'h0000_0006, 32'hDEAD_BEEF, "R2 R8 R9 ID mismatch");
    chk(rspContext == 32'hDE80_2000 && rspEntryHi == 32'h0040_0006, "R9 fault regs",
        {rspContext, rspEntryHi}, {32'hDE80_2000, 32'h0040_0006});
    // R11: valid falls one edge later, results hold
    @(negedge clk);
    chk(rspValid == 0 && rspEntryHi == 32'h0040_0006, "R11 valid drop, hold",
        {rspValid, rspEntryHi}, {1'b0, 32'h0040_0006});

    // entry 1: global, 16 KiB pages (mask bits 14:13), half bit is 14
    doWrite(1, 32'h0080_0000, 32'h0000_6000, 8'h77, 1, 32'h3000_0000, 32'h4000_0000, 1, 1, 1, 1);
    doLookup(32'h0080_3ABC, 1, 32'h0000_0001, 32'h0, "R2 R3 global, masked tag even");
    chk(rspPhys == 32'h3000_3ABC, "R3 R4 16K even", rspPhys, 32'h3000_3ABC);
    doLookup(32'h0080_7ABC, 0, 32'h0000_0002, 32'h0, "R3 R4 16K odd");
    chk(rspPhys == 32'h4000_3ABC, "R4 16K odd phys", rspPhys, 32'h4000_3ABC);
    doLookup(32'h0080_8000, 0, 32'h0000_0002, 32'h0, "R3 tag bit above mask");

    // entry 2: invalid even half
    doWrite(2, 32'h00C0_0000, 0, 8'h05, 0, 32'h5000_0000, 32'h6000_0000, 0, 1, 1, 1);
    doLookup(32'h00C0_0004, 0, 32'h0000_0005, 32'h0, "R5 invalid even half");
    chk(rspCode == 2'd1 && rspRead == 0, "R5 R7 invalid no perm",
        {rspCode, rspRead}, {2'd1, 1'b0});

    // entries 3 and 4: same tag, lowest wins
    doWrite(4, 32'h0100_0000, 0, 8'h09, 0, 32'h7000_0000, 32'h7100_0000, 1, 1, 1, 1);
    doWrite(3, 32'h0100_0000, 0, 8'h09, 0, 32'h7200_0000, 32'h7300_0000, 1, 1, 0, 0);
    doLookup(32'h0100_0044, 0, 32'h0000_0009, 32'h0, "R10 lowest index");
    chk(rspPhys == 32'h7200_0044, "R10 entry 3 frame", rspPhys, 32'h7200_0044);
    doLookup(32'h0100_0044, 1, 32'h0000_0009, 32'h0, "R10 lowest index store");

    // R11: write and lookup at the same edge
    model(32'h0040_0010, 0, 32'h5, 32'h0, code, ph, rd, wo, octx, oeh);
    @(negedge clk);
    driveWrite(0, 32'h0040_0000, 0, 8'h05, 0, 32'h0900_0000, 32'h0A00_0000, 0, 0, 0, 0);
    lkValid = 1; lkAddr = 32'h0040_0010; lkWrite = 0; curEntryHi = 32'h5; curContext = 0;
    @(negedge clk);
    wrEn = 0; lkValid = 0;
    checkResp("R11 same-edge lookup sees old entry", code, ph, rd, wo, octx, oeh);
    modelWrite(0, 32'h0040_0000, 0, 8'h05, 0, 32'h0900_0000, 32'h0A00_0000, 0, 0, 0, 0);
    doLookup(32'h0040_0010, 0, 32'h5, 32'h0, "R11 R5 new entry after edge");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 6 == 0) begin
        int k; logic [31:0] msk, fm;
        k = int'($urandom % N);
        case ($urandom % 3)
          0: msk = 32'h0;
          1: msk = 32'h0000_6000;
          default: msk = 32'h001F_E000;
        endcase
        fm = msk | 32'h1FFF;
        doWrite(k, $urandom & ~fm, msk, 8'($urandom % 4), ($urandom % 4) == 0,
                $urandom & ~(fm >> 1), $urandom & ~(fm >> 1),
                ($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % 2 == 1, $urandom % 2 == 1);
      end else begin
        int k; logic [31:0] a, eh, fm;
        k  = int'($urandom % N);
        fm = mMask[k] | 32'h1FFF;
        if (($urandom % 4) != 0 && mUsed[k]) a = (mVpn[k] & ~fm) | ($urandom & fm);
        else a = $urandom;
        eh = {$urandom} & 32'hFFFF_FF00 | ($urandom % 4);
        model(a, 1'($urandom % 2), eh, $urandom, code, ph, rd, wo, octx, oeh);
        doLookup(a, lkWrite, eh, curContext, "");
      end
    end
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule